// File: doc/BRIEF.md
# Loop Replay Buffer

This block sits after instruction decode and watches the stream of decoded instructions for a short loop. The first decoded instruction that is not a backward branch opens a capture, and every following instruction is written into a small local store. If a predicted-taken backward branch arrives whose target equals the address of the first captured instruction, the body is complete. The block then switches to replay. It raises a gate output that shuts down fetch and holds most of decode idle, and it streams the stored body from its own storage, wrapping from the closing branch back to the first entry.

A body is accepted only if it has room in the store (32 entries by default), holds no more than two forward branches, and is closed by exactly one backward branch. Any other shape abandons the capture. Replay continues until one of three things happens: a flush or redirect arrives, execution reports that the closing branch fell through, or a forward branch inside the body resolves taken to an address outside the captured range. In each case the gate drops and the block returns to idle. Replay output uses a valid/ready handshake.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset, `fe_gate` and `rep_valid` are low.
- R2: A capture starts on a valid decoded instruction that is not a backward branch, taken while idle. Replay begins only when a backward branch with `dec_taken` high targets the address of that first instruction. From the next cycle, `fe_gate` and `rep_valid` are high, and the body is presented in capture order starting at the first entry, each item as the pair {`rep_pc`, `rep_instr`}.
- R3: After the closing backward branch is presented, replay wraps to the first entry. This includes a body that fills all DEPTH entries.
- R4: Replay advances one entry per cycle in which `rep_valid` and `rep_ready` are both high. While `rep_ready` is low, `rep_pc` and `rep_instr` hold their values.
- R5: A body of exactly DEPTH entries, closing branch included, is accepted. A capture that receives a further instruction once DEPTH entries are stored is abandoned.
- R6: Up to two forward branches (`dec_fwd_br`) are accepted in a body. A third forward branch abandons the capture.
- R7: A backward branch received during capture that is not taken, or that targets any address other than the first captured one, abandons the capture. A backward branch received while idle does not start a capture.
- R8: `flush` high abandons a capture or ends replay. `fe_gate` and `rep_valid` are low in the following cycle.
- R9: During replay, a resolution with `res_bwd_br` high and `res_taken` low ends replay in the next cycle. A taken resolution of the closing branch does not end it.
- R10: During replay, a resolution with `res_bwd_br` low and `res_taken` high ends replay if `res_target` lies outside the range from the first captured address to the closing branch address, inclusive. A target inside that range does not end replay.
- R11: While replaying, decoded input is ignored and the replay sequence is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_pc | input | PCW | Address of the decoded instruction |
| dec_instr | input | IW | Decoded instruction payload |
| dec_fwd_br | input | 1 | Instruction is a forward branch |
| dec_bwd_br | input | 1 | Instruction is a backward branch |
| dec_taken | input | 1 | Branch predicted taken |
| dec_target | input | PCW | Predicted branch target |
| res_valid | input | 1 | Branch resolution from execute |
| res_bwd_br | input | 1 | Resolved branch is backward |
| res_taken | input | 1 | Resolved branch was taken |
| res_target | input | PCW | Resolved target address |
| flush | input | 1 | Redirect or pipeline flush |
| rep_valid | output | 1 | Replay item present |
| rep_ready | input | 1 | Consumer accepts replay item |
| rep_pc | output | PCW | Address of replay item |
| rep_instr | output | IW | Payload of replay item |
| fe_gate | output | 1 | High while fetch and decode are shut down |

## Verification
The closing branch is written on a clock edge. Replay state, `fe_gate` and the first item are visible right after that edge, so the first item is due zero cycles after the closing send completes. Each later item is due one handshake edge after the previous one. A flush, a not-taken closing resolution or an outside-range forward resolution clears `fe_gate` and `rep_valid` one edge after it is applied. Inputs change just after the rising edge. The scoreboard monitor pops an expected item at the falling edge whenever valid and ready are both high, and the directed checks read the outputs one time step after the edge that makes them due.

// File: rtl/lrb_pkg.sv
// Shared types for the loop replay buffer.
// Assumes nothing beyond a single clock domain.
package lrb_pkg;
    typedef enum logic [1:0] {
        LRB_IDLE    = 2'd0,
        LRB_CAPTURE = 2'd1,
        LRB_REPLAY  = 2'd2
    } lrb_mode_e;
endpackage

// File: rtl/lrb_store.sv
// Entry store: one write port and one asynchronous read port.
// Assumes wr_idx < DEPTH whenever wr_en is high. Contents are not reset.
module lrb_store #(
    parameter int DEPTH = 32,
    parameter int W     = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // write one captured entry
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // present the entry under the replay pointer
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/lrb_exit.sv
// Replay exit detection: flush, fall-through of the closing branch,
// or a taken forward branch that leaves the captured address range.
// Assumes start_pc <= last_pc for a captured body.
module lrb_exit #(
    parameter int PCW = 32
) (
    input  logic           flush,
    input  logic           res_valid,
    input  logic           res_bwd_br,
    input  logic           res_taken,
    input  logic [PCW-1:0] res_target,
    input  logic [PCW-1:0] start_pc,
    input  logic [PCW-1:0] last_pc,
    output logic           exit_req
);
    logic outside;
    logic fall_through;
    logic fwd_escape;

    // classify the resolution against the captured range
    always_comb begin
        outside      = (res_target < start_pc) || (res_target > last_pc);
        fall_through = res_valid && res_bwd_br && !res_taken;
        fwd_escape   = res_valid && !res_bwd_br && res_taken && outside;
        exit_req     = flush || fall_through || fwd_escape;
    end
endmodule

// File: rtl/lrb_ctrl.sv
// Mode controller: idle, capture and replay. Counts captured entries and
// forward branches, qualifies the closing branch and steps the replay pointer.
// Assumes dec_fwd_br and dec_bwd_br are never both high.
module lrb_ctrl
    import lrb_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int PCW     = 32,
    parameter int MAX_FWD = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int FW     = $clog2(MAX_FWD + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dec_valid,
    input  logic [PCW-1:0] dec_pc,
    input  logic           dec_fwd_br,
    input  logic           dec_bwd_br,
    input  logic           dec_taken,
    input  logic [PCW-1:0] dec_target,
    input  logic           flush,
    input  logic           exit_req,
    input  logic           rep_ready,
    output logic           wr_en,
    output logic [AW-1:0]  wr_idx,
    output logic [AW-1:0]  rd_idx,
    output logic           replaying,
    output logic [PCW-1:0] start_pc,
    output logic [PCW-1:0] last_pc
);
    lrb_mode_e     mode;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic [FW-1:0] fwd_cnt;
    logic [AW-1:0] rptr;
    logic          full;
    logic          fwd_over;
    logic          close_ok;
    logic          cap_ok;
    logic          open_ok;

    // qualify the current decoded instruction against the capture rules
    always_comb begin
        full     = (cnt == CW'(DEPTH));
        fwd_over = dec_fwd_br && (fwd_cnt == FW'(MAX_FWD));
        close_ok = dec_bwd_br && dec_taken && (dec_target == start_pc);
        open_ok  = (mode == LRB_IDLE) && dec_valid && !flush && !dec_bwd_br;
        cap_ok   = (mode == LRB_CAPTURE) && dec_valid && !flush && !full
                   && !fwd_over && (!dec_bwd_br || close_ok);
        wr_en    = open_ok || cap_ok;
        wr_idx   = (mode == LRB_IDLE) ? '0 : cnt[AW-1:0];
        rd_idx   = rptr;
        replaying = (mode == LRB_REPLAY);
    end

    // mode, counters and replay pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= LRB_IDLE;
            cnt      <= '0;
            len      <= '0;
            fwd_cnt  <= '0;
            rptr     <= '0;
            start_pc <= '0;
            last_pc  <= '0;
        end else begin
            case (mode)
                LRB_IDLE: begin
                    if (open_ok) begin
                        mode     <= LRB_CAPTURE;
                        cnt      <= CW'(1);
                        fwd_cnt  <= dec_fwd_br ? FW'(1) : '0;
                        start_pc <= dec_pc;
                    end
                end
                LRB_CAPTURE: begin
                    if (flush) begin
                        mode <= LRB_IDLE;
                    end else if (dec_valid) begin
                        if (!cap_ok) begin
                            mode <= LRB_IDLE;
                        end else if (dec_bwd_br) begin
                            mode    <= LRB_REPLAY;
                            len     <= cnt + CW'(1);
                            last_pc <= dec_pc;
                            rptr    <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                            if (dec_fwd_br) fwd_cnt <= fwd_cnt + FW'(1);
                        end
                    end
                end
                LRB_REPLAY: begin
                    if (exit_req) begin
                        mode <= LRB_IDLE;
                    end else if (rep_ready) begin
                        rptr <= (rptr == AW'(len - CW'(1))) ? '0 : rptr + AW'(1);
                    end
                end
                default: mode <= LRB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/loop_replay_buf.sv
// Loop replay buffer top: captures a short loop body from decode and replays
// it from local storage while fetch and decode are gated off.
// Assumes the consumer holds rep_ready meaningful only while rep_valid is high.
module loop_replay_buf #(
    parameter int DEPTH   = 32,
    parameter int PCW     = 32,
    parameter int IW      = 32,
    parameter int MAX_FWD = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int EW     = PCW + IW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dec_valid,
    input  logic [PCW-1:0] dec_pc,
    input  logic [IW-1:0]  dec_instr,
    input  logic           dec_fwd_br,
    input  logic           dec_bwd_br,
    input  logic           dec_taken,
    input  logic [PCW-1:0] dec_target,
    input  logic           res_valid,
    input  logic           res_bwd_br,
    input  logic           res_taken,
    input  logic [PCW-1:0] res_target,
    input  logic           flush,
    output logic           rep_valid,
    input  logic           rep_ready,
    output logic [PCW-1:0] rep_pc,
    output logic [IW-1:0]  rep_instr,
    output logic           fe_gate
);
    logic           wr_en;
    logic [AW-1:0]  wr_idx;
    logic [AW-1:0]  rd_idx;
    logic [EW-1:0]  rd_data;
    logic           replaying;
    logic           exit_req;
    logic [PCW-1:0] start_pc;
    logic [PCW-1:0] last_pc;

    lrb_ctrl #(.DEPTH(DEPTH), .PCW(PCW), .MAX_FWD(MAX_FWD)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_fwd_br(dec_fwd_br),
        .dec_bwd_br(dec_bwd_br), .dec_taken(dec_taken), .dec_target(dec_target),
        .flush(flush), .exit_req(exit_req), .rep_ready(rep_ready),
        .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .replaying(replaying),
        .start_pc(start_pc), .last_pc(last_pc)
    );

    lrb_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data({dec_pc, dec_instr}),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    lrb_exit #(.PCW(PCW)) u_exit (
        .flush(flush), .res_valid(res_valid), .res_bwd_br(res_bwd_br),
        .res_taken(res_taken), .res_target(res_target),
        .start_pc(start_pc), .last_pc(last_pc), .exit_req(exit_req)
    );

    // drive the replay stream and the fetch/decode gate
    always_comb begin
        rep_valid = replaying;
        fe_gate   = replaying;
        rep_pc    = rd_data[EW-1:IW];
        rep_instr = rd_data[IW-1:0];
    end
endmodule

// File: rtl/lrb_checker.sv
// Protocol checker for the loop replay buffer, bound to the top module.
// Assumes the bound signals keep the top module's port names.
module lrb_checker #(
    parameter int PCW = 32,
    parameter int IW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dec_valid,
    input logic           dec_bwd_br,
    input logic           dec_taken,
    input logic           res_valid,
    input logic           res_bwd_br,
    input logic           res_taken,
    input logic           flush,
    input logic           rep_valid,
    input logic           rep_ready,
    input logic [PCW-1:0] rep_pc,
    input logic [IW-1:0]  rep_instr,
    input logic           fe_gate
);
    AST_GATE_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_gate && !(dec_valid && dec_bwd_br && dec_taken)) |=> !fe_gate); // R2

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready) |=> (!rep_valid || ($stable(rep_pc) && $stable(rep_instr)))); // R4

    AST_FLUSH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!fe_gate && !rep_valid)); // R8

    AST_FALL_THROUGH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && res_valid && res_bwd_br && !res_taken) |=> !fe_gate); // R9
endmodule

bind loop_replay_buf lrb_checker #(.PCW(PCW), .IW(IW)) u_chk (.*);

// File: tb/loop_replay_buf_bench.sv
module loop_replay_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PCW = 32;
    localparam int IW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dec_valid = 1'b0;
    logic [PCW-1:0] dec_pc = '0;
    logic [IW-1:0]  dec_instr = '0;
    logic           dec_fwd_br = 1'b0;
    logic           dec_bwd_br = 1'b0;
    logic           dec_taken = 1'b0;
    logic [PCW-1:0] dec_target = '0;
    logic           res_valid = 1'b0;
    logic           res_bwd_br = 1'b0;
    logic           res_taken = 1'b0;
    logic [PCW-1:0] res_target = '0;
    logic           flush = 1'b0;
    logic           rep_valid;
    logic           rep_ready = 1'b0;
    logic [PCW-1:0] rep_pc;
    logic [IW-1:0]  rep_instr;
    logic           fe_gate;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [63:0] expq[$];

    loop_replay_buf u_loop_replay_buf (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [IW-1:0] instr_of(input logic [PCW-1:0] pc);
        return 32'hC0DE_0000 ^ pc;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare each accepted replay item
    always @(negedge clk) begin
        if (rst_n && rep_valid && rep_ready && !done) begin
            if (expq.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2: actual %0h expected no item", {rep_pc, rep_instr});
            end else begin
                check("R2/R3 replay item", {rep_pc, rep_instr}, expq.pop_front());
            end
        end
    end

    task automatic send(input logic [PCW-1:0] pc, input bit fwd, input bit bwd,
                        input bit taken, input logic [PCW-1:0] tgt);
        dec_valid = 1; dec_pc = pc; dec_instr = instr_of(pc);
        dec_fwd_br = fwd; dec_bwd_br = bwd; dec_taken = taken; dec_target = tgt;
        @(posedge clk); #1;
        dec_valid = 0; dec_fwd_br = 0; dec_bwd_br = 0; dec_taken = 0;
    endtask

    // capture a body of n entries at base; fmask marks forward branches
    task automatic cap_loop(input logic [PCW-1:0] base, input int n, input logic [31:0] fmask);
        for (int i = 0; i < n - 1; i++) send(base + PCW'(4*i), fmask[i], 0, 0, '0);
        send(base + PCW'(4*(n-1)), 0, 1, 1, base);
    endtask

    // driver: push expected replay items
    task automatic expect_items(input logic [PCW-1:0] base, input int n, input int first, input int count);
        for (int i = 0; i < count; i++) begin
            logic [PCW-1:0] pc;
            pc = base + PCW'(4*((first + i) % n));
            expq.push_back({pc, instr_of(pc)});
        end
    endtask

    task automatic pulse_ready(input int n, input bit junk);
        rep_ready = 1;
        if (junk) begin
            dec_valid = 1; dec_pc = 32'hDEAD_0000; dec_instr = 32'hBAD0_BAD0;
            dec_bwd_br = 1; dec_taken = 1; dec_target = 32'hDEAD_0000;
        end
        repeat (n) @(posedge clk);
        #1;
        rep_ready = 0; dec_valid = 0; dec_bwd_br = 0; dec_taken = 0;
    endtask

    task automatic do_flush();
        flush = 1; @(posedge clk); #1; flush = 0;
    endtask

    task automatic resolve(input bit bwd, input bit taken, input logic [PCW-1:0] tgt);
        res_valid = 1; res_bwd_br = bwd; res_taken = taken; res_target = tgt;
        @(posedge clk); #1;
        res_valid = 0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 gate", fe_gate, 0);
        check("R1 valid", rep_valid, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R2 R3 R11: four-entry loop, replay with junk decode input
        cap_loop(32'h100, 4, 32'h0);
        check("R2 gate on", fe_gate, 1);
        expect_items(32'h100, 4, 0, 10);
        pulse_ready(10, 1);
        check("R11 queue drained", expq.size(), 0);
        // R4: stalled output holds
        #4;
        check("R4 held pc", rep_pc, 32'h108);
        repeat (2) @(posedge clk);
        #1;
        check("R4 still held", {rep_pc, rep_instr}, {32'h108, instr_of(32'h108)});
        // R8: flush ends replay
        do_flush();
        check("R8 gate off", fe_gate, 0);
        check("R8 valid off", rep_valid, 0);

        // R9: closing branch resolutions
        cap_loop(32'h200, 3, 32'h0);
        expect_items(32'h200, 3, 0, 2);
        pulse_ready(2, 0);
        resolve(1, 1, 32'h200);
        check("R9 taken keeps replay", fe_gate, 1);
        resolve(1, 0, 32'h200);
        check("R9 fall-through exit", fe_gate, 0);

        // R6 R10: two forward branches accepted; forward resolutions
        cap_loop(32'h300, 4, 32'h6);
        check("R6 two forward ok", fe_gate, 1);
        expect_items(32'h300, 4, 0, 3);
        pulse_ready(3, 0);
        resolve(0, 1, 32'h308);
        check("R10 inside keeps replay", fe_gate, 1);
        resolve(0, 1, 32'h400);
        check("R10 outside exit", {fe_gate, rep_valid}, 0);

        // R5 R3: full-depth body and wrap
        cap_loop(32'h1000, 32, 32'h0);
        check("R5 full body accepted", fe_gate, 1);
        expect_items(32'h1000, 32, 0, 34);
        pulse_ready(34, 0);
        check("R3 wrap drained", expq.size(), 0);
        do_flush();

        // R5: body past depth is abandoned
        for (int i = 0; i < 33; i++) send(32'h2000 + PCW'(4*i), 0, 0, 0, '0);
        send(32'h2000 + PCW'(4*33), 0, 1, 1, 32'h2000);
        check("R5 overflow abandoned", {fe_gate, rep_valid}, 0);

        // R6: third forward branch
        send(32'h600, 0, 0, 0, '0);
        send(32'h604, 1, 0, 0, '0);
        send(32'h608, 1, 0, 0, '0);
        send(32'h60C, 1, 0, 0, '0);
        send(32'h610, 0, 1, 1, 32'h600);
        check("R6 third forward abandoned", fe_gate, 0);

        // R7: wrong target, not-taken close
        send(32'h500, 0, 0, 0, '0);
        send(32'h504, 0, 0, 0, '0);
        send(32'h508, 0, 1, 1, 32'h504);
        check("R7 wrong target", fe_gate, 0);
        send(32'h50C, 0, 1, 1, 32'h500);
        check("R7 idle backward ignored", fe_gate, 0);
        send(32'h700, 0, 0, 0, '0);
        send(32'h704, 0, 1, 0, 32'h700);
        check("R7 not-taken close", fe_gate, 0);

        // R8: flush during capture
        send(32'h800, 0, 0, 0, '0);
        send(32'h804, 0, 0, 0, '0);
        do_flush();
        send(32'h808, 0, 1, 1, 32'h800);
        check("R8 capture flushed", {fe_gate, rep_valid}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule